// File: doc/BRIEF.md
# Half-Duplex Transmit Status Tracker

This block follows one packet attempt on a half-duplex Ethernet MAC and builds the status word for that packet. A packet context opens with a `txStart` pulse. While the context is open, the block counts collision events. A collision that arrives once the frame's byte counter has reached the late window is treated as a late collision. The block also notes whether the MAC had to defer. When the deferral check is enabled, it times each continuous deferral period in bit-time ticks.

The context closes in one of two ways. A normal `txEnd` closes it, or an abort condition closes it: a late collision, too many collisions, or excessive deferral. On close, the block raises `statusValid` for one cycle. On an abort it also pulses `abortTx` so the MAC stops sending. The status word then holds its value until the next `txStart`. Backoff timing, serialization and register access belong to other blocks.

Top module: `txstat_tracker`

## Requirements
- R1: After reset, `statusValid` and `abortTx` are 0 and `statusWord` is all zeros.
- R2: Field `statusWord[6:3]` shows the number of normal collisions (collision with `byteCount` < `LATE_BYTES`, default 64) seen in the current packet, saturating at 15; `txStart` clears it to 0.
- R3: A `txEnd` sampled while a packet is open produces `statusValid` high for exactly one cycle after that clock edge, with `abortTx` low.
- R4: The `COLL_LIMIT`-th normal collision (default 16) sets `statusWord[8]`, and `statusValid` and `abortTx` are both high after that same edge; `statusWord[6:3]` then reads 15.
- R5: A collision sampled with `byteCount` >= `LATE_BYTES` sets `statusWord[9]` and pulses `statusValid` and `abortTx` after that edge; it does not add to the collision count.
- R6: If `deferring` is sampled high at any edge while a packet is open, `statusWord[0]` is set in that packet's status.
- R7: With `deferChkEn` high, the bit tick that makes one continuous deferral period exceed `DEFER_LIMIT` ticks (default 24288) sets `statusWord[2]` and pulses `statusValid` and `abortTx` after that edge; the exact limit count alone does not abort.
- R8: With `deferChkEn` low, deferral of any length never sets `statusWord[2]` and never aborts.
- R9: The deferral tick count returns to zero whenever `deferring` is sampled low, so two separate periods of `DEFER_LIMIT` ticks each do not abort.
- R10: Bits 7 and 1 and every bit above 9 of `statusWord` are always 0.
- R11: `collision`, `txEnd` and `deferring` have no effect while no packet is open; `txStart` takes priority over every other input in its cycle.
- R12: After `statusValid`, `statusWord` holds its value until the next `txStart`, which clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| deferChkEn | input | 1 | Enables the excessive-deferral abort |
| deferring | input | 1 | MAC is deferring to carrier this cycle |
| collision | input | 1 | One-cycle collision event |
| bitTick | input | 1 | One pulse per bit time |
| byteCount | input | BYTE_W | Bytes of the current frame already sent |
| txStart | input | 1 | Opens a new packet context |
| txEnd | input | 1 | Normal end of the packet |
| statusValid | output | 1 | One-cycle strobe: status word is final |
| abortTx | output | 1 | One-cycle strobe: stop transmitting now |
| statusWord | output | STATUS_W | Packed transmit status |

## Verification
Every result is registered once. A `txEnd`, a collision or a tick seen at a clock edge shows up in `statusValid`, `abortTx` and `statusWord` right after that same edge, and nothing is pipelined further. The bench drives each input on a falling edge and samples all outputs on the next falling edge, so each check sees exactly the edge that consumed its stimulus. It then checks, one cycle later, that the strobes have dropped and the word has held. The sweeps count collisions and deferral ticks edge by edge against a smaller deferral limit. The expected abort lands precisely on tick `DEFER_LIMIT+1` or on collision `COLL_LIMIT`, whether ticks come every cycle or every other cycle.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrAll;      // new packet: clear every flag, counter and timer
    logic incColl;     // count one normal collision
    logic setLate;     // record late collision
    logic setExcColl;  // record collision limit reached
    logic setDefer;    // record that deferral happened
    logic setExcDefer; // record deferral over the limit
    logic tmrInc;      // one bit time of deferral
    logic tmrClr;      // deferral period over
  } ctrlStrb_t;

  localparam int unsigned FIELD_MAX = 15;

endpackage

// File: rtl/txstat_datapath.sv
module txstat_datapath
  import txstat_pkg::*;
#(
  parameter int unsigned COLL_LIMIT  = 16,
  parameter int unsigned DEFER_LIMIT = 24288,
  parameter int unsigned STATUS_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  output logic                tmrAtLimit,
  output logic                lastColl,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int unsigned CNT_W = $clog2(COLL_LIMIT + 1);
  localparam int unsigned TMR_W = $clog2(DEFER_LIMIT + 1);

  logic [CNT_W-1:0] collCnt;
  logic [TMR_W-1:0] deferTmr;
  logic             flagLate, flagExcColl, flagExcDefer, flagDefer;
  logic [3:0]       collField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collCnt      <= '0;
      flagLate     <= 1'b0;
      flagExcColl  <= 1'b0;
      flagExcDefer <= 1'b0;
      flagDefer    <= 1'b0;
    end else if (strb.clrAll) begin
      collCnt      <= '0;
      flagLate     <= 1'b0;
      flagExcColl  <= 1'b0;
      flagExcDefer <= 1'b0;
      flagDefer    <= 1'b0;
    end else begin
      if (strb.incColl && (int'(collCnt) < COLL_LIMIT)) collCnt <= collCnt + 1'b1;
      if (strb.setLate)     flagLate     <= 1'b1;
      if (strb.setExcColl)  flagExcColl  <= 1'b1;
      if (strb.setExcDefer) flagExcDefer <= 1'b1;
      if (strb.setDefer)    flagDefer    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          deferTmr <= '0;
    else if (strb.clrAll || strb.tmrClr) deferTmr <= '0;
    else if (strb.tmrInc)               deferTmr <= deferTmr + 1'b1;
  end

  assign tmrAtLimit = (deferTmr == TMR_W'(DEFER_LIMIT));
  assign lastColl   = (int'(collCnt) == COLL_LIMIT - 1);
  assign collField  = (int'(collCnt) >= FIELD_MAX) ? 4'(FIELD_MAX) : 4'(collCnt);

  always_comb begin
    statusWord      = '0;
    statusWord[9]   = flagLate;
    statusWord[8]   = flagExcColl;
    statusWord[6:3] = collField;
    statusWord[2]   = flagExcDefer;
    statusWord[0]   = flagDefer;
  end

endmodule

// File: rtl/txstat_ctrl.sv
module txstat_ctrl
  import txstat_pkg::*;
#(
  parameter int unsigned BYTE_W     = 16,
  parameter int unsigned LATE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              deferChkEn,
  input  logic              deferring,
  input  logic              collision,
  input  logic              bitTick,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic              txStart,
  input  logic              txEnd,
  input  logic              tmrAtLimit,
  input  logic              lastColl,
  output ctrlStrb_t         strb,
  output logic              statusValid,
  output logic              abortTx
);

  logic pktOpen;
  logic isLate, isNormColl, overDefer, anyAbort, closing;

  always_comb begin
    strb       = '0;
    isLate     = 1'b0;
    isNormColl = 1'b0;
    overDefer  = 1'b0;
    anyAbort   = 1'b0;
    closing    = 1'b0;
    if (txStart) begin
      strb.clrAll = 1'b1;
    end else if (pktOpen) begin
      isLate           = collision && (int'(byteCount) >= LATE_BYTES);
      isNormColl       = collision && !isLate;
      overDefer        = deferChkEn && deferring && bitTick && tmrAtLimit;
      strb.setLate     = isLate;
      strb.incColl     = isNormColl;
      strb.setExcColl  = isNormColl && lastColl;
      strb.setExcDefer = overDefer;
      strb.setDefer    = deferring;
      strb.tmrInc      = deferring && bitTick && !tmrAtLimit;
      strb.tmrClr      = !deferring;
      anyAbort         = strb.setLate || strb.setExcColl || strb.setExcDefer;
      closing          = anyAbort || txEnd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktOpen     <= 1'b0;
      statusValid <= 1'b0;
      abortTx     <= 1'b0;
    end else begin
      statusValid <= closing;
      abortTx     <= anyAbort;
      if (txStart)      pktOpen <= 1'b1;
      else if (closing) pktOpen <= 1'b0;
    end
  end

endmodule

// File: rtl/txstat_tracker.sv
module txstat_tracker
  import txstat_pkg::*;
#(
  parameter int unsigned BYTE_W      = 16,
  parameter int unsigned LATE_BYTES  = 64,
  parameter int unsigned COLL_LIMIT  = 16,
  parameter int unsigned DEFER_LIMIT = 24288,
  parameter int unsigned STATUS_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                deferChkEn,
  input  logic                deferring,
  input  logic                collision,
  input  logic                bitTick,
  input  logic [BYTE_W-1:0]   byteCount,
  input  logic                txStart,
  input  logic                txEnd,
  output logic                statusValid,
  output logic                abortTx,
  output logic [STATUS_W-1:0] statusWord
);

  ctrlStrb_t strb;
  logic      tmrAtLimit, lastColl;

  txstat_ctrl #(.BYTE_W(BYTE_W), .LATE_BYTES(LATE_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .deferChkEn(deferChkEn), .deferring(deferring),
    .collision(collision), .bitTick(bitTick), .byteCount(byteCount),
    .txStart(txStart), .txEnd(txEnd), .tmrAtLimit(tmrAtLimit),
    .lastColl(lastColl), .strb(strb), .statusValid(statusValid), .abortTx(abortTx)
  );

  txstat_datapath #(.COLL_LIMIT(COLL_LIMIT), .DEFER_LIMIT(DEFER_LIMIT),
                    .STATUS_W(STATUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tmrAtLimit(tmrAtLimit),
    .lastColl(lastColl), .statusWord(statusWord)
  );

endmodule

// File: rtl/txstat_checks.sv
module txstat_checks #(
  parameter int unsigned STATUS_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                deferChkEn,
  input logic                txStart,
  input logic                statusValid,
  input logic                abortTx,
  input logic [STATUS_W-1:0] statusWord
);

  // R3: the valid strobe never lasts two cycles
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  // R4 R5 R7: an abort always comes with valid and a cause bit
  a_r4_abort_has_valid: assert property (@(posedge clk) disable iff (!rstN)
    abortTx |-> statusValid);
  a_r5_abort_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    abortTx |-> (statusWord[9] || statusWord[8] || statusWord[2]));

  // R4: collision limit reported with a full count field
  a_r4_field_full: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[8] |-> (statusWord[6:3] == 4'd15));

  // R8: excess deferral only appears when the check was enabled
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[2]) |-> $past(deferChkEn));

  // R10: reserved bits stay zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[7] == 1'b0) && (statusWord[1] == 1'b0) && ((statusWord >> 10) == '0));

  // R12: a new packet clears the word
  a_r12_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> (statusWord == '0));

endmodule

bind txstat_tracker txstat_checks #(.STATUS_W(STATUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .deferChkEn(deferChkEn), .txStart(txStart),
  .statusValid(statusValid), .abortTx(abortTx), .statusWord(statusWord)
);

// File: tb/txstat_tracker_test.sv
`timescale 1ns/1ps
module txstat_tracker_test;

  localparam int unsigned LIM  = 40;
  localparam int unsigned LATE = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        deferChkEn = 1'b0, deferring = 1'b0, collision = 1'b0, bitTick = 1'b0;
  logic [15:0] byteCount = '0;
  logic        txStart = 1'b0, txEnd = 1'b0;
  logic        statusValid, abortTx;
  logic [31:0] statusWord;

  int nChk = 0;
  int nBad = 0;

  txstat_tracker #(.BYTE_W(16), .LATE_BYTES(LATE), .COLL_LIMIT(16),
                   .DEFER_LIMIT(LIM), .STATUS_W(32)) uut (
    .clk(clk), .rstN(rstN), .deferChkEn(deferChkEn), .deferring(deferring),
    .collision(collision), .bitTick(bitTick), .byteCount(byteCount),
    .txStart(txStart), .txEnd(txEnd), .statusValid(statusValid),
    .abortTx(abortTx), .statusWord(statusWord)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic startPkt();
    txStart = 1'b1; cyc(); txStart = 1'b0;
  endtask

  task automatic collide(input int bc);
    collision = 1'b1; byteCount = 16'(bc); cyc(); collision = 1'b0;
  endtask

  task automatic endPkt(input logic [31:0] expWord, input string req);
    txEnd = 1'b1; cyc(); txEnd = 1'b0;
    chk({req, " valid"}, {31'b0, statusValid}, 32'd1);
    chk({req, " abort"}, {31'b0, abortTx}, 32'd0);
    chk({req, " word"}, statusWord, expWord);
    cyc();
    chk("R3 valid drops", {31'b0, statusValid}, 32'd0);
    chk("R12 word holds", statusWord, expWord);
  endtask

  // one deferral period of d ticks; sparse puts an idle cycle before each tick
  task automatic deferRun(input logic en, input int d, input bit sparse);
    bit aborted = 0;
    bit expAb;
    deferChkEn = en;
    startPkt();
    deferring = 1'b1;
    for (int i = 1; i <= d && !aborted; i++) begin
      if (sparse) begin
        bitTick = 1'b0; cyc();
        chk("R7 no tick no abort", {31'b0, statusValid}, 32'd0);
      end
      bitTick = 1'b1; cyc();
      expAb = en && (i == LIM + 1);
      chk(en ? "R7 abort tick" : "R8 no abort", {31'b0, abortTx}, {31'b0, expAb});
      chk("R7 valid", {31'b0, statusValid}, {31'b0, expAb});
      if (expAb) begin
        chk("R7 word", statusWord, 32'h5);
        aborted = 1;
      end
    end
    bitTick = 1'b0; deferring = 1'b0;
    if (!aborted) endPkt(32'h1, en ? "R6 deferred" : "R8 deferred only");
    else begin
      cyc();
      chk("R7 abort drops", {31'b0, abortTx}, 32'd0);
    end
  endtask

  initial begin
    #(8ns * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1 valid", {31'b0, statusValid}, 32'd0);
    chk("R1 abort", {31'b0, abortTx}, 32'd0);
    chk("R1 word", statusWord, 32'd0);
    rstN = 1'b1;
    cyc();

    // R11: events with no open packet
    collision = 1'b1; txEnd = 1'b1; deferring = 1'b1; bitTick = 1'b1; byteCount = 16'd100;
    cyc();
    collision = 1'b0; txEnd = 1'b0; deferring = 1'b0; bitTick = 1'b0;
    chk("R11 idle valid", {31'b0, statusValid}, 32'd0);
    chk("R11 idle abort", {31'b0, abortTx}, 32'd0);
    chk("R11 idle word", statusWord, 32'd0);
    // R11: txStart wins over txEnd and collision in its cycle
    txStart = 1'b1; txEnd = 1'b1; collision = 1'b1; cyc();
    txStart = 1'b0; txEnd = 1'b0; collision = 1'b0;
    chk("R11 start priority", {31'b0, statusValid}, 32'd0);
    endPkt(32'd0, "R11 start priority word");

    // R2 R3: 0..15 normal collisions
    for (int n = 0; n <= 15; n++) begin
      startPkt();
      for (int k = 0; k < n; k++) begin
        collide(LATE - 1 - k);
        chk("R2 no close", {31'b0, statusValid}, 32'd0);
      end
      endPkt(32'(n) << 3, "R2 count");
    end

    // R4: sixteenth collision aborts
    startPkt();
    for (int k = 1; k <= 16; k++) begin
      collide(5);
      chk("R4 abort", {31'b0, abortTx}, {31'b0, k == 16});
      chk("R4 valid", {31'b0, statusValid}, {31'b0, k == 16});
    end
    chk("R4 word", statusWord, (32'd1 << 8) | (32'd15 << 3));
    cyc();
    chk("R12 held after abort", statusWord, (32'd1 << 8) | (32'd15 << 3));
    startPkt();
    chk("R12 cleared", statusWord, 32'd0);
    endPkt(32'd0, "R12 fresh packet");

    // R5 R10: late window boundary
    foreach (byteCount[i]) begin end
    for (int b = 0; b < 4; b++) begin
      int bc;
      bc = (b == 0) ? LATE - 1 : (b == 1) ? LATE : (b == 2) ? LATE + 1 : 1500;
      for (int k = 0; k <= 3; k++) begin
        startPkt();
        for (int j = 0; j < k; j++) collide(3);
        collide(bc);
        if (bc >= LATE) begin
          chk("R5 abort", {31'b0, abortTx}, 32'd1);
          chk("R5 valid", {31'b0, statusValid}, 32'd1);
          chk("R5 word", statusWord, (32'd1 << 9) | (32'(k) << 3));
          chk("R10 reserved", statusWord & 32'hFFFF_FC82, 32'd0);
          cyc();
        end else begin
          chk("R5 inside window", {31'b0, statusValid}, 32'd0);
          endPkt(32'(k + 1) << 3, "R5 normal count");
        end
      end
    end

    // R6 R7 R8: deferral sweeps
    deferRun(1'b1, 1, 1'b0);
    deferRun(1'b1, LIM, 1'b0);
    deferRun(1'b1, LIM + 1, 1'b0);
    deferRun(1'b1, LIM + 1, 1'b1);
    deferRun(1'b0, LIM + 1, 1'b0);
    deferRun(1'b0, LIM + 5, 1'b1);

    // R9: two separate periods of LIM ticks
    deferChkEn = 1'b1;
    startPkt();
    for (int p = 0; p < 2; p++) begin
      deferring = 1'b1; bitTick = 1'b1;
      for (int i = 0; i < LIM; i++) begin
        cyc();
        chk("R9 no abort", {31'b0, abortTx}, 32'd0);
      end
      deferring = 1'b0; bitTick = 1'b0;
      cyc();
    end
    endPkt(32'h1, "R9 deferred flag");
    deferChkEn = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule